// File: doc/BRIEF.md
# Six-Channel Event-Driven PWM Generator

This block produces six pulse-width-modulated outputs from one shared time base. A 12-bit prescaler divides the system clock into counter steps, and a 16-bit counter runs up, down, or up-then-down (center aligned) between zero and a programmed period. Each channel holds its own 16-bit compare value. Each channel also holds four action fields that say what its output does when the counter reaches zero, the period, the compare value while rising, or the compare value while falling.

The raw waveform of each channel passes through a per-channel inverter and then a per-channel override that can pin the pin to a fixed level. Software programs the block through a single-cycle write strobe and reads it back through a read strobe with a registered return. Period and compare values are double-buffered, so a new value only takes effect at a period boundary. The counter value and registered one-cycle pulses for each counter event are brought out for neighbouring logic such as converters or capture units.

Top module: `pwm_gen`

## Requirements
- R1: The counter advances only on a prescaler step, which occurs once every (divider + 1) clock cycles; the divider sits in bits [11:0] at address 1, and writing address 3 restarts the step count at zero.
- R2: Mode 0 (address 0, bits [1:0]) counts 0,1,…,P and then returns to 0, where P is the active period.
- R3: Mode 1 counts P, P−1, …, 0 and then reloads P; after a clear it begins at 0 and reloads P on its first step.
- R4: Mode 2 counts up from 0 to P, then down to 0, and repeats, turning at both ends; a compare hit while rising is an up hit, and a hit while falling is a down hit, with a hit at P counted as up.
- R5: An active period of 0 holds the counter still and raises no events.
- R6: Each channel's action byte (address 16+c) has a 2-bit field for the zero event in bits [1:0], the compare-up hit in [3:2], the period event in [5:4] and the compare-down hit in [7:6]; code 0 keeps the output, 1 drives it low, 2 drives it high, 3 toggles it. The output changes one clock after the step that saw the event.
- R7: When events coincide on one step, their actions are applied in this order: zero, then period, then compare, so the last applied action decides the result.
- R8: A written period (address 2) or compare (address 8+c) is held in a shadow register. It moves into the active register on the zero event in modes 0 and 1, on the period event in mode 2, and on every cycle while the active period is 0.
- R9: A set bit c of the polarity register (address 4) inverts output c from the clock after the write.
- R10: A set bit c of the mask enable register (address 5) forces output c to bit c of the mask level register (address 6) after the polarity stage; all-zero enables leave every output unmasked.
- R11: A write to address 3 sets the counter to 0 and the count direction to up on the write edge, and suppresses events on that edge.
- R12: Reading addresses 0, 1, 2, 4, 5, 6, 8+c and 16+c returns the written value one clock after the read strobe; address 3 returns the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data, valid the clock after rd_en |
| pwm_out | output | 6 | Final channel outputs |
| count_o | output | 16 | Shared counter value |
| evt_zero | output | 1 | Pulse: the step just taken was at zero |
| evt_period | output | 1 | Pulse: the step just taken was at the period |
| evt_cmp_up | output | 6 | Per-channel pulse: rising compare hit |
| evt_cmp_dn | output | 6 | Per-channel pulse: falling compare hit |

## Verification
The compare hit of a channel can fall on the same step as the zero event when its compare value is 0, or on the same step as the period event when its compare value equals the period. The bench sets up both cases on four channels, each pairing a set or clear action with a toggle or the opposite level, so that only the stated order gives the predicted level. It then checks that each channel settles to the level left by the action applied last.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {CNT_UP = 2'd0, CNT_DOWN = 2'd1, CNT_UPDN = 2'd2} cnt_mode_e;
  typedef enum logic [1:0] {ACT_KEEP = 2'd0, ACT_LOW = 2'd1, ACT_HIGH = 2'd2, ACT_TOGGLE = 2'd3} act_e;

  localparam int unsigned ACT_W    = 8;
  localparam int unsigned F_ZERO   = 0;
  localparam int unsigned F_CMP_UP = 2;
  localparam int unsigned F_PERIOD = 4;
  localparam int unsigned F_CMP_DN = 6;

  localparam int unsigned A_MODE     = 0;
  localparam int unsigned A_DIV      = 1;
  localparam int unsigned A_PERIOD   = 2;
  localparam int unsigned A_CLEAR    = 3;
  localparam int unsigned A_POL      = 4;
  localparam int unsigned A_MSKEN    = 5;
  localparam int unsigned A_MSKLVL   = 6;
  localparam int unsigned A_CMP_BASE = 8;
  localparam int unsigned A_ACT_BASE = 16;

  function automatic logic apply_act(input logic cur, input logic [1:0] code);
    case (act_e'(code))
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] cnt_q;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && !clr && $stable(div)) |=> (!tick || div == '0));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] per_shd,
  output logic [CW-1:0] count,
  output logic          step,
  output logic          cnt_up,
  output logic          ld_stb,
  output logic          ev_zero,
  output logic          ev_prd
);
  import pwm_pkg::*;

  logic [CW-1:0] cnt_q, per_q;
  logic          up_q;
  logic          run;

  assign run     = (per_q != '0);
  assign step    = tick && run && !clr;
  assign ev_zero = step && (cnt_q == '0);
  assign ev_prd  = step && (cnt_q == per_q);
  assign cnt_up  = (mode == CNT_DOWN) ? 1'b0 : (mode == CNT_UPDN) ? up_q : 1'b1;
  assign ld_stb  = !run || ((mode == CNT_UPDN) ? ev_prd : ev_zero);
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      per_q <= '0;
      up_q  <= 1'b1;
    end else begin
      if (ld_stb) per_q <= per_shd;
      if (clr) begin
        cnt_q <= '0;
        up_q  <= 1'b1;
      end else if (step) begin
        case (mode)
          CNT_DOWN: cnt_q <= (cnt_q == '0) ? per_shd : cnt_q - 1'b1;
          CNT_UPDN: begin
            if (up_q) begin
              if (cnt_q >= per_q) begin
                up_q  <= 1'b0;
                cnt_q <= per_q - 1'b1;
              end else cnt_q <= cnt_q + 1'b1;
            end else begin
              if (cnt_q == '0) begin
                up_q  <= 1'b1;
                cnt_q <= CW'(1);
              end else cnt_q <= cnt_q - 1'b1;
            end
          end
          default: cnt_q <= (cnt_q >= per_q) ? '0 : cnt_q + 1'b1;
        endcase
      end
    end
  end

  // R1
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt_q));
  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (per_q == '0 && !clr) |=> $stable(cnt_q));
  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0 && up_q));
  // R4
  turn_down_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == CNT_UPDN && ev_prd && up_q) |=> !up_q);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_cmp,
  input  logic                     wr_act,
  input  logic [CW-1:0]            wdata_cmp,
  input  logic [pwm_pkg::ACT_W-1:0] wdata_act,
  input  logic                     ld_stb,
  input  logic                     step,
  input  logic                     cnt_up,
  input  logic [CW-1:0]            count,
  input  logic                     ev_zero,
  input  logic                     ev_prd,
  input  logic                     pol,
  input  logic                     msk_en,
  input  logic                     msk_lvl,
  output logic                     pwm_q,
  output logic                     evt_cu_q,
  output logic                     evt_cd_q,
  output logic [CW-1:0]            cmp_shd_q,
  output logic [pwm_pkg::ACT_W-1:0] act_q
);
  import pwm_pkg::*;

  logic [CW-1:0] cmp_act_q;
  logic          wave_q, wave_nx;
  logic          hit, hit_up, hit_dn;

  assign hit    = step && (count == cmp_act_q);
  assign hit_up = hit && cnt_up;
  assign hit_dn = hit && !cnt_up;

  always_comb begin
    wave_nx = wave_q;
    if (ev_zero) wave_nx = apply_act(wave_nx, act_q[F_ZERO +: 2]);
    if (ev_prd)  wave_nx = apply_act(wave_nx, act_q[F_PERIOD +: 2]);
    if (hit_up)  wave_nx = apply_act(wave_nx, act_q[F_CMP_UP +: 2]);
    if (hit_dn)  wave_nx = apply_act(wave_nx, act_q[F_CMP_DN +: 2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_shd_q <= '0;
      cmp_act_q <= '0;
      act_q     <= '0;
      wave_q    <= 1'b0;
      pwm_q     <= 1'b0;
      evt_cu_q  <= 1'b0;
      evt_cd_q  <= 1'b0;
    end else begin
      if (wr_cmp) cmp_shd_q <= wdata_cmp;
      if (wr_act) act_q     <= wdata_act;
      if (ld_stb) cmp_act_q <= cmp_shd_q;
      wave_q   <= wave_nx;
      pwm_q    <= msk_en ? msk_lvl : (wave_nx ^ pol);
      evt_cu_q <= hit_up;
      evt_cd_q <= hit_dn;
    end
  end

  // R6
  wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ev_zero && !ev_prd && !hit) |=> $stable(wave_q));
  // R9
  pol_apply_chk: assert property (@(posedge clk) disable iff (rst)
    !msk_en |=> (pwm_q == (wave_q ^ $past(pol))));
  // R10
  mask_force_chk: assert property (@(posedge clk) disable iff (rst)
    msk_en |=> (pwm_q == $past(msk_lvl)));
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int NCH = 6,
  parameter int CW  = 16,
  parameter int PW  = 12,
  parameter int AW  = 5,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] pwm_out,
  output logic [CW-1:0]  count_o,
  output logic           evt_zero,
  output logic           evt_period,
  output logic [NCH-1:0] evt_cmp_up,
  output logic [NCH-1:0] evt_cmp_dn
);
  import pwm_pkg::*;

  localparam int MW = 2;

  logic [MW-1:0]  mode_q;
  logic [PW-1:0]  div_q;
  logic [CW-1:0]  per_shd_q;
  logic [NCH-1:0] pol_q, msken_q, msklvl_q;
  logic           clr, tick, step, cnt_up, ld_stb, ev_zero, ev_prd;
  logic [CW-1:0]  count;
  logic [CW-1:0]  cmp_rb [NCH];
  logic [ACT_W-1:0] act_rb [NCH];
  logic [DW-1:0]  rd_nx;

  function automatic logic wr_hit(input int unsigned a);
    return wr_en && (wr_addr == AW'(a));
  endfunction

  assign clr = wr_hit(A_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0; div_q <= '0; per_shd_q <= '0;
      pol_q <= '0; msken_q <= '0; msklvl_q <= '0;
      evt_zero <= 1'b0; evt_period <= 1'b0; rd_data <= '0;
    end else begin
      if (wr_hit(A_MODE))   mode_q    <= wr_data[MW-1:0];
      if (wr_hit(A_DIV))    div_q     <= wr_data[PW-1:0];
      if (wr_hit(A_PERIOD)) per_shd_q <= wr_data[CW-1:0];
      if (wr_hit(A_POL))    pol_q     <= wr_data[NCH-1:0];
      if (wr_hit(A_MSKEN))  msken_q   <= wr_data[NCH-1:0];
      if (wr_hit(A_MSKLVL)) msklvl_q  <= wr_data[NCH-1:0];
      evt_zero   <= ev_zero;
      evt_period <= ev_prd;
      if (rd_en) rd_data <= rd_nx;
    end
  end

  pwm_prescaler #(.PW(PW)) u_div (
    .clk(clk), .rst(rst), .clr(clr), .div(div_q), .tick(tick));

  pwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick), .mode(mode_q),
    .per_shd(per_shd_q), .count(count), .step(step), .cnt_up(cnt_up),
    .ld_stb(ld_stb), .ev_zero(ev_zero), .ev_prd(ev_prd));

  assign count_o = count;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst),
      .wr_cmp(wr_hit(A_CMP_BASE + c)), .wr_act(wr_hit(A_ACT_BASE + c)),
      .wdata_cmp(wr_data[CW-1:0]), .wdata_act(wr_data[ACT_W-1:0]),
      .ld_stb(ld_stb), .step(step), .cnt_up(cnt_up), .count(count),
      .ev_zero(ev_zero), .ev_prd(ev_prd),
      .pol(pol_q[c]), .msk_en(msken_q[c]), .msk_lvl(msklvl_q[c]),
      .pwm_q(pwm_out[c]), .evt_cu_q(evt_cmp_up[c]), .evt_cd_q(evt_cmp_dn[c]),
      .cmp_shd_q(cmp_rb[c]), .act_q(act_rb[c]));
  end

  always_comb begin
    rd_nx = '0;
    if (rd_addr == AW'(A_MODE))   rd_nx = DW'(mode_q);
    if (rd_addr == AW'(A_DIV))    rd_nx = DW'(div_q);
    if (rd_addr == AW'(A_PERIOD)) rd_nx = DW'(per_shd_q);
    if (rd_addr == AW'(A_CLEAR))  rd_nx = DW'(count);
    if (rd_addr == AW'(A_POL))    rd_nx = DW'(pol_q);
    if (rd_addr == AW'(A_MSKEN))  rd_nx = DW'(msken_q);
    if (rd_addr == AW'(A_MSKLVL)) rd_nx = DW'(msklvl_q);
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == AW'(A_CMP_BASE + c)) rd_nx = DW'(cmp_rb[c]);
      if (rd_addr == AW'(A_ACT_BASE + c)) rd_nx = DW'(act_rb[c]);
    end
  end

  // R12
  rd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_pwm_gen.sv
`timescale 1ns/1ps
module tb_pwm_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, count_o;
  logic [5:0]  pwm_out, evt_cmp_up, evt_cmp_dn;
  logic        evt_zero, evt_period;

  pwm_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out),
    .count_o(count_o), .evt_zero(evt_zero), .evt_period(evt_period),
    .evt_cmp_up(evt_cmp_up), .evt_cmp_dn(evt_cmp_dn));

  always #2.5 clk = ~clk;

  typedef struct { int due; int sel; logic [15:0] exp; string req; } item_t;
  item_t q[$];
  int cyc = 0, n_chk = 0, n_bad = 0, t0 = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] observe(input int sel);
    case (sel)
      0: return 16'(pwm_out);
      1: return count_o;
      2: return rd_data;
      3: return 16'(evt_zero);
      4: return 16'(evt_period);
      6: return 16'(pwm_out[0]);
      default: return 16'(pwm_out[3:0]);
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [15:0] got;
      it = q.pop_front();
      got = observe(it.sel);
      n_chk++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s sel=%0d cyc=%0d actual=%h expected=%h", it.req, it.sel, cyc, got, it.exp);
      end
    end
  end

  function automatic void push(input int due, input int sel, input logic [15:0] exp, input string req);
    item_t it;
    it.due = due; it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endfunction

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [15:0] exp, input string req);
    rd_en = 1'b1; rd_addr = 5'(a);
    push(cyc + 1, 2, exp, req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic clear_now();
    wr(3, 0);
    t0 = cyc;
  endtask

  function automatic int tri_wave(input int m, input int p);
    int v;
    v = m % (2 * p);
    return (v <= p) ? v : 2 * p - v;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // reset state
    push(cyc + 1, 0, 16'h0, "R5 reset outputs");
    push(cyc + 1, 1, 16'h0, "R5 reset counter");
    drain();

    // R2 + R6: up mode, period 5, compares 1..6, zero->high, cmp-up->low
    wr(0, 0);
    wr(2, 5);
    for (int c = 0; c < 6; c++) begin
      wr(8 + c, c + 1);
      wr(16 + c, 16'h06);
    end
    idle(20);
    clear_now();
    for (int k = 1; k <= 12; k++) begin
      int v;
      logic [15:0] e;
      v = (k - 1) % 6;
      e = '0;
      for (int c = 0; c < 6; c++) e[c] = (v < c + 1);
      push(t0 + k, 1, 16'(k % 6), "R2 up count");
      push(t0 + k, 0, e, "R6 actions up mode");
      push(t0 + k, 3, 16'(v == 0), "R6 zero pulse");
    end
    drain();

    // R3: down mode
    wr(0, 1);
    idle(20);
    clear_now();
    for (int k = 1; k <= 12; k++) begin
      push(t0 + k, 1, 16'(5 - ((k - 1) % 6)), "R3 down count");
      if (k >= 2) push(t0 + k, 4, 16'(((k - 2) % 6) == 0), "R3 period pulse");
    end
    drain();

    // R4: up-down mode, period 3, ch0 cmp 2, up-hit high, down-hit low
    wr(0, 2);
    wr(2, 3);
    wr(8, 2);
    wr(16, 16'h48);
    idle(20);
    clear_now();
    for (int k = 1; k <= 12; k++) begin
      int m;
      m = (k - 1) % 6;
      push(t0 + k, 1, 16'(tri_wave(k, 3)), "R4 up-down count");
      if (k >= 3) push(t0 + k, 6, 16'(m == 2 || m == 3), "R4 center-aligned output");
    end
    drain();

    // R7: coincident events, up mode, period 4
    wr(0, 0);
    wr(2, 4);
    wr(8, 0);  wr(16, 16'h0E);   // zero high, then cmp toggle -> low
    wr(9, 0);  wr(17, 16'h0B);   // zero toggle, then cmp high -> high
    wr(10, 4); wr(18, 16'h18);   // period low, then cmp high -> high
    wr(11, 4); wr(19, 16'h24);   // period high, then cmp low -> low
    idle(20);
    clear_now();
    for (int k = 5; k <= 14; k++) push(t0 + k, 7, 16'h6, "R7 event order");
    drain();

    // R9 / R10: polarity and mask on steady channels
    wr(4, 1);
    push(cyc + 1, 7, 16'h7, "R9 polarity inverts ch0");
    drain();
    wr(6, 16'h02);
    wr(5, 16'h03);
    push(cyc + 1, 7, 16'h6, "R10 mask forces levels");
    drain();
    wr(5, 0);
    push(cyc + 1, 7, 16'h7, "R10 mask released");
    drain();
    wr(4, 0);
    push(cyc + 1, 7, 16'h6, "R9 polarity removed");
    drain();

    // R8: period shadow takes effect at the next zero event
    idle(10);
    clear_now();
    wr(2, 2);
    begin
      int seq [9] = '{1, 2, 3, 4, 0, 1, 2, 0, 1};
      for (int k = 1; k <= 9; k++) push(t0 + k, 1, 16'(seq[k - 1]), "R8 shadow period");
    end
    drain();

    // R1: prescaler divide by 3, period 3
    wr(1, 2);
    wr(2, 3);
    idle(30);
    clear_now();
    for (int k = 1; k <= 15; k++) begin
      push(t0 + k, 1, 16'((k / 3) % 4), "R1 prescaled count");
      push(t0 + k, 3, 16'((k % 3 == 0) && (((k / 3) - 1) % 4 == 0)), "R1 prescaled zero pulse");
    end
    drain();
    wr(1, 0);

    // R5 + R11: zero period stops the counter; clear returns it to 0
    wr(2, 0);
    idle(20);
    begin
      logic [15:0] held;
      held = count_o;
      push(cyc + 4, 1, held, "R5 counter held");
    end
    drain();
    clear_now();
    for (int k = 1; k <= 6; k++) begin
      push(t0 + k, 1, 16'h0, "R11 cleared and R5 stopped");
      push(t0 + k, 3, 16'h0, "R5 no events");
    end
    drain();

    // R12: readback
    wr(10, 16'h1234);
    wr(18, 16'h00A5);
    wr(2, 7);
    wr(6, 16'h15);
    rd(10, 16'h1234, "R12 compare readback");
    rd(18, 16'h00A5, "R12 action readback");
    rd(2, 16'h0007, "R12 period readback");
    rd(6, 16'h0015, "R12 mask level readback");
    rd(0, 16'h0000, "R12 mode readback");
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule